// File: doc/BRIEF.md
# Logarithmic attenuation decoder

The block turns an 8-bit attenuation code into a 17-bit linear magnitude word for a multiplying ladder converter. Every code step means a fixed 0.375 dB of extra attenuation, so the decoder has to map a logarithmic code onto a binary gain. The low nibble of the code picks one of sixteen mantissas, which together span a single 6 dB octave. The high nibble sets a binary right shift, and each shift is taken as exactly 6 dB. When the high nibble is all ones the output is forced to zero (mute).

A processor writes codes through an 8-bit data port with active-low chip select and write strobe. A build parameter sets the load style. In edge style the code is captured on the rising edge of the write strobe, and a refresh counter then keeps the port busy for a set number of clocks. A write that arrives while the port is busy is dropped and sets a sticky overrun flag. In level style the holding register follows the bus for as long as chip select and write are both low.

Top module: `logatt_decoder`

## Requirements
- R1: After reset the held code is 0, `gain_out` is 65536 (bit 16 set, all other bits clear), and `busy` and `overrun` are low.
- R2: For a held code N of 0 to 239, `gain_out` equals round(65536 × 10^(−0.375·(N mod 16)/20)) shifted right by N div 16 (N[7:4] is the shift, N[3:0] selects the mantissa).
- R3: For a held code of 240 to 255 (N[7:4] = 4'b1111), `gain_out` is 0.
- R4: Over codes 0 to 239, `gain_out` never rises as the code rises, and only code 0 sets bit 16.
- R5: In edge style, a code is captured at the clock where `wr_n` is sampled high after being sampled low, with `cs_n` sampled low. `gain_out` shows the decoded value one clock after that capture. A strobe with `cs_n` high has no effect.
- R6: In level style, the held code takes `data_in` at every clock where `cs_n` and `wr_n` are both low. When either one is high, the held code stays as it is.
- R7: In edge style, `busy` goes high after an accepted capture and stays high for exactly REFRESH_CYC clocks. In level style `busy` stays low.
- R8: In edge style, a rising strobe that arrives while `busy` is high leaves the held code unchanged and sets `overrun`. Only reset clears `overrun`.
- R9: In edge style, changes on `data_in` while `wr_n` is held low have no effect until the rising strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Attenuation code bus |
| gain_out | output | 17 | Linear magnitude word for the ladder |
| busy | output | 1 | Refresh interval in progress (edge style) |
| overrun | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The bench builds two copies of the block. The first uses edge loading with REFRESH_CYC set to 4, so each write's busy window can be checked at both its last busy clock and its first free clock, and a second strobe can be placed inside the window. The second uses level loading, where the latch is transparent on every clock, so the full set of 256 codes can be swept back to back. Both sweeps cover every code, the mute band included, and the outputs are compared with a mantissa-and-shift model computed in real arithmetic.

// File: rtl/logatt_pkg.sv
package logatt_pkg;
  localparam int CODE_W   = 8;
  localparam int FINE_W   = 4;
  localparam int COARSE_W = CODE_W - FINE_W;
  localparam int GAIN_W   = 17;

  typedef logic [CODE_W-1:0]   code_t;
  typedef logic [FINE_W-1:0]   fine_t;
  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [GAIN_W-1:0]   gain_t;

  localparam gain_t GAIN_FULL = gain_t'(1) << (GAIN_W - 1);

  // round(2^16 * 10^(-0.375*k/20)), k = 0..15
  function automatic gain_t mant_of(fine_t k);
    gain_t m;
    case (k)
      4'd0:    m = 17'd65536;
      4'd1:    m = 17'd62767;
      4'd2:    m = 17'd60115;
      4'd3:    m = 17'd57574;
      4'd4:    m = 17'd55142;
      4'd5:    m = 17'd52812;
      4'd6:    m = 17'd50580;
      4'd7:    m = 17'd48443;
      4'd8:    m = 17'd46396;
      4'd9:    m = 17'd44435;
      4'd10:   m = 17'd42558;
      4'd11:   m = 17'd40760;
      4'd12:   m = 17'd39037;
      4'd13:   m = 17'd37388;
      4'd14:   m = 17'd35808;
      default: m = 17'd34295;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/logatt_wrport.sv
module logatt_wrport
  import logatt_pkg::*;
#(
  parameter bit EDGE_LOAD   = 1'b1,
  parameter int REFRESH_CYC = 150
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  wr_n,
  input  code_t data_in,
  output code_t code_q,
  output logic  load_q,
  output logic  busy_o,
  output logic  overrun_o
);
  localparam int CNT_W = (REFRESH_CYC < 1) ? 1 : $clog2(REFRESH_CYC + 1);

  logic  accept;
  code_t code_d;
  logic  load_d;

  generate
    if (EDGE_LOAD) begin : g_edge
      logic             wr_prev_q;
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             ovr_q, ovr_d;
      logic             rise, busy_w;

      assign busy_w = (cnt_q != '0);
      assign rise   = wr_n & ~wr_prev_q & ~cs_n;
      assign accept = rise & ~busy_w;

      always_comb begin
        cnt_d = cnt_q;
        if (accept)      cnt_d = CNT_W'(REFRESH_CYC);
        else if (busy_w) cnt_d = cnt_q - 1'b1;
        ovr_d = ovr_q | (rise & busy_w);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_prev_q <= 1'b1;
          cnt_q     <= '0;
          ovr_q     <= 1'b0;
        end else begin
          wr_prev_q <= wr_n;
          cnt_q     <= cnt_d;
          ovr_q     <= ovr_d;
        end
      end

      assign busy_o    = busy_w;
      assign overrun_o = ovr_q;
    end else begin : g_level
      assign accept    = ~cs_n & ~wr_n;
      assign busy_o    = 1'b0;
      assign overrun_o = 1'b0;
    end
  endgenerate

  always_comb begin
    code_d = code_q;
    if (accept) code_d = data_in;
    load_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      load_q <= 1'b0;
    end else begin
      code_q <= code_d;
      load_q <= load_d;
    end
  end
endmodule

// File: rtl/logatt_mant.sv
module logatt_mant
  import logatt_pkg::*;
(
  input  fine_t fine_i,
  output gain_t mant_o
);
  always_comb mant_o = mant_of(fine_i);
endmodule

// File: rtl/logatt_scale.sv
module logatt_scale
  import logatt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd_en,
  input  coarse_t coarse_i,
  input  gain_t   mant_i,
  output gain_t   gain_q
);
  gain_t stg [COARSE_W+1];
  gain_t gain_d;
  logic  mute;

  assign stg[0] = mant_i;

  genvar gi;
  generate
    for (gi = 0; gi < COARSE_W; gi++) begin : g_stage
      assign stg[gi+1] = coarse_i[gi] ? (stg[gi] >> (1 << gi)) : stg[gi];
    end
  endgenerate

  always_comb begin
    mute   = &coarse_i;
    gain_d = mute ? '0 : stg[COARSE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_q <= GAIN_FULL;
    else if (upd_en) gain_q <= gain_d;
  end
endmodule

// File: rtl/logatt_decoder.sv
module logatt_decoder
  import logatt_pkg::*;
#(
  parameter bit EDGE_LOAD   = 1'b1,
  parameter int REFRESH_CYC = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [CODE_W-1:0] data_in,
  output logic [GAIN_W-1:0] gain_out,
  output logic              busy,
  output logic              overrun
);
  code_t code_q;
  logic  load_q;
  gain_t mant;

  logatt_wrport #(.EDGE_LOAD(EDGE_LOAD), .REFRESH_CYC(REFRESH_CYC)) u_wrport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .data_in(data_in),
    .code_q(code_q), .load_q(load_q), .busy_o(busy), .overrun_o(overrun)
  );

  logatt_mant u_mant (
    .fine_i(code_q[FINE_W-1:0]), .mant_o(mant)
  );

  logatt_scale u_scale (
    .clk(clk), .rst_n(rst_n), .upd_en(load_q),
    .coarse_i(code_q[CODE_W-1:FINE_W]), .mant_i(mant), .gain_q(gain_out)
  );
endmodule

// File: rtl/logatt_decoder_chk.sv
module logatt_decoder_chk
  import logatt_pkg::*;
#(
  parameter bit EDGE_LOAD   = 1'b1,
  parameter int REFRESH_CYC = 150
) (
  input logic  clk,
  input logic  rst_n,
  input logic  cs_n,
  input logic  wr_n,
  input code_t data_in,
  input code_t code_q,
  input gain_t gain_out,
  input logic  busy,
  input logic  overrun
);
  a_r2_fullscale: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_q) == '0) |-> (gain_out == GAIN_FULL));

  a_r3_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(code_q[CODE_W-1:FINE_W])) |-> (gain_out == '0));

  a_r4_top_bit_only_code0: assert property (@(posedge clk) disable iff (!rst_n)
    gain_out[GAIN_W-1] |-> ($past(code_q) == '0));

  a_r5_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(code_q));

  generate
    if (EDGE_LOAD) begin : g_edge_chk
      a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_n) && wr_n && !cs_n && !busy)
        |=> (code_q == $past(data_in)));

      a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(code_q));

      a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

      a_r9_low_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> $stable(code_q));
    end else begin : g_level_chk
      a_r6_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |=> (code_q == $past(data_in)));

      a_r7_level_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !overrun);
    end
  endgenerate
endmodule

bind logatt_decoder logatt_decoder_chk #(
  .EDGE_LOAD(EDGE_LOAD), .REFRESH_CYC(REFRESH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .data_in(data_in),
  .code_q(code_q), .gain_out(gain_out), .busy(busy), .overrun(overrun)
);

// File: tb/test_logatt_decoder.sv
module test_logatt_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int REF_CYC    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, wr_n;
  logic [7:0]  data;
  logic [16:0] gain;
  logic        busy, ovr;
  logic        cs2_n, wr2_n;
  logic [7:0]  data2;
  logic [16:0] gain2;
  logic        busy2, ovr2;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logatt_decoder #(.EDGE_LOAD(1'b1), .REFRESH_CYC(REF_CYC)) i_logatt_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .data_in(data),
    .gain_out(gain), .busy(busy), .overrun(ovr)
  );

  logatt_decoder #(.EDGE_LOAD(1'b0), .REFRESH_CYC(REF_CYC)) i_logatt_decoder_lvl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs2_n), .wr_n(wr2_n), .data_in(data2),
    .gain_out(gain2), .busy(busy2), .overrun(ovr2)
  );

  function automatic int ref_gain(int c);
    real m;
    int  mi;
    if (c >= 240) return 0;
    m  = 65536.0 * (10.0 ** (-0.375 * real'(c % 16) / 20.0));
    mi = $rtoi(m + 0.5);
    return mi >> (c / 16);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_write(input logic [7:0] c);
    @(negedge clk) begin data = c; cs_n = 1'b0; wr_n = 1'b0; end
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int prev;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; data = '0;
    cs2_n = 1'b1; wr2_n = 1'b1; data2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(gain == 17'd65536, "R1 gain", gain, 65536);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(ovr == 1'b0, "R1 overrun", ovr, 0);
    chk(gain2 == 17'd65536, "R1 level gain", gain2, 65536);

    // Edge-style sweep of all codes: R2, R3, R4, R7
    prev = 65536;
    for (int c = 0; c < 256; c++) begin
      edge_write(8'(c));
      if (c < 240) chk(int'(gain) == ref_gain(c), "R2 edge sweep", gain, ref_gain(c));
      else         chk(gain == '0, "R3 edge mute", gain, 0);
      if (c > 0 && c < 240) chk(int'(gain) <= prev, "R4 monotonic", gain, prev);
      if (c > 0) chk(gain[16] == 1'b0, "R4 top bit", gain[16], 0);
      prev = gain;
      repeat (REF_CYC - 2) @(negedge clk);
      chk(busy == 1'b1, "R7 busy last cycle", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R7 busy released", busy, 0);
    end
    chk(ovr == 1'b0, "R8 no false overrun", ovr, 0);

    // R8 write inside refresh window is dropped
    edge_write(8'h10);
    @(negedge clk) begin data = 8'h20; cs_n = 1'b0; wr_n = 1'b0; end
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk(int'(gain) == ref_gain(16), "R8 dropped write", gain, ref_gain(16));
    chk(ovr == 1'b1, "R8 overrun set", ovr, 1);
    repeat (REF_CYC) @(negedge clk);
    edge_write(8'h05);
    chk(int'(gain) == ref_gain(5), "R8 later write", gain, ref_gain(5));
    chk(ovr == 1'b1, "R8 overrun sticky", ovr, 1);
    repeat (REF_CYC) @(negedge clk);

    // R5 strobe with chip select high
    @(negedge clk) begin data = 8'h33; cs_n = 1'b1; wr_n = 1'b0; end
    @(negedge clk) wr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(gain) == ref_gain(5), "R5 cs high ignored", gain, ref_gain(5));

    // R9 data moving under a low strobe, then R5 latency
    @(negedge clk) begin data = 8'h40; cs_n = 1'b0; wr_n = 1'b0; end
    @(negedge clk) data = 8'h41;
    @(negedge clk) data = 8'h42;
    @(negedge clk);
    chk(int'(gain) == ref_gain(5), "R9 low strobe holds", gain, ref_gain(5));
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk) cs_n = 1'b1;
    chk(int'(gain) == ref_gain(5), "R5 not yet updated", gain, ref_gain(5));
    @(negedge clk);
    chk(int'(gain) == ref_gain(66), "R5 R9 captured last data", gain, ref_gain(66));

    // Level-style sweep: R6, R2, R3
    @(negedge clk) begin cs2_n = 1'b0; wr2_n = 1'b0; end
    for (int c = 0; c < 256; c++) begin
      @(negedge clk) data2 = 8'(c);
      @(negedge clk);
      @(negedge clk);
      if (c < 240) chk(int'(gain2) == ref_gain(c), "R6 R2 level sweep", gain2, ref_gain(c));
      else         chk(gain2 == '0, "R6 R3 level mute", gain2, 0);
    end
    chk(busy2 == 1'b0, "R7 level never busy", busy2, 0);
    @(negedge clk) begin wr2_n = 1'b1; data2 = 8'h07; end
    repeat (3) @(negedge clk);
    chk(gain2 == '0, "R6 hold with wr high", gain2, 0);
    @(negedge clk) wr2_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(int'(gain2) == ref_gain(7), "R6 transparent again", gain2, ref_gain(7));

    finish_run();
  end
endmodule